// File: doc/BRIEF.md
# Switchable One-Line Pixel Delay Router

This block handles one colour component for a liquid-crystal panel driver that alternates pixel polarity by dot and by line. Two pixel streams enter, and two leave. For one input the block forwards the pixel with no added line delay. The other input passes through a single-line store, so its output carries the pixel at the same column of the previous line. Two select inputs choose which input gets the line delay and which output each path feeds. A third input inverts the sense of the first select.

The line store is a circular buffer. Its address returns to zero at the start of every line. The start of a line is the edge of the horizontal sync input chosen by an edge-select pin, either rising or falling. The delayed path and the undelayed path have the same fixed pipeline length, so both outputs stay pixel-aligned.

Both pixel streams run at the full clock rate, one pixel per clock. There is no valid or ready signal. The block cannot apply back-pressure, and the source must never stall. Every clock edge consumes one pixel from each input and produces one on each output. Clear must be held low for at least one clock while sync is at its idle level. Each sync pulse must have an idle phase of at least six clocks.

Top module: `line_delay_swapper`

## Requirements
- R1: While `clr_n` is low, both output ports read 0, whatever the inputs carry.
- R2: The undelayed path presents an input pixel on its output port exactly 3 clock edges after the edge that captures it.
- R3: The delayed path presents, 3 clock edges after the pixel at column c of a line is captured, the delayed-source pixel captured at column c of the previous line. Column 0 is the first pixel captured together with the selected sync edge.
- R4: With effective select A=0 and B=0, `in2_pix` is forwarded undelayed to `out1_pix`, and `in1_pix` is line-delayed to `out2_pix`.
- R5: With effective A=0 and B=1, `in2_pix` is line-delayed to `out1_pix`, and `in1_pix` is forwarded undelayed to `out2_pix`.
- R6: With effective A=1 and B=0, `in1_pix` is forwarded undelayed to `out1_pix`, and `in2_pix` is line-delayed to `out2_pix`.
- R7: With effective A=1 and B=1, `in1_pix` is line-delayed to `out1_pix`, and `in2_pix` is forwarded undelayed to `out2_pix`.
- R8: The effective select A equals `sel_a` XOR `sel_a_inv`, so setting `sel_a_inv` to 1 swaps the R4/R6 and R5/R7 behaviours.
- R9: With `hs_rise_sel`=1 a line starts at a rising edge of `hsync`. With `hs_rise_sel`=0 it starts at a falling edge. An edge of the other polarity does not restart the line.
- R10: A line has room for LINE_DEPTH columns. Once column LINE_DEPTH-1 has been written, the address holds and no further writes happen until the next line start. Columns 0..LINE_DEPTH-1 of such a long line are still delayed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| hsync | input | 1 | Horizontal sync |
| hs_rise_sel | input | 1 | Line-start edge: 1 selects rising, 0 selects falling |
| sel_a | input | 1 | Path select A |
| sel_b | input | 1 | Path select B |
| sel_a_inv | input | 1 | Inverts the sense of select A |
| in1_pix | input | PIX_W | Pixel input port 1 |
| in2_pix | input | PIX_W | Pixel input port 2 |
| out1_pix | output | PIX_W | Pixel output port 1 (registered) |
| out2_pix | output | PIX_W | Pixel output port 2 (registered) |

## Verification
Every result on either output is due on the third clock edge after the edge that captures its input pixel. For the delayed path, that input pixel is the one at the same column of the previous line. The bench drives inputs and samples outputs at falling clock edges. It holds each pixel's expected output values in a three-entry queue and compares the oldest entry at the third falling edge after the pixel was driven. Blanking pixels are marked unchecked, and so are delayed results past the line capacity. Column numbering is anchored on the pixel that the bench presents together with the sync transition.

// File: rtl/ldly_pkg.sv
package ldly_pkg;

  // Routing decision carried down the pipeline with each pixel.
  typedef struct packed {
    logic dly_from_in2;  // 1: input 2 feeds the line store
    logic dly_to_out1;   // 1: delayed path drives output 1
  } route_t;

  // Decode the select pins into a routing decision.
  function automatic route_t decode_route(input logic a, input logic b,
                                          input logic a_inv);
    route_t r;
    logic   eff_a;
    eff_a          = a ^ a_inv;
    r.dly_from_in2 = eff_a ^ b;
    r.dly_to_out1  = b;
    return r;
  endfunction

endpackage

// File: rtl/ldly_sync_edge.sv
module ldly_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_i,
  input  logic rise_sel_i,
  output logic line_start_o
);
  logic hs_q, hs_p, rise_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      hs_p   <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      hs_q   <= hsync_i;
      hs_p   <= hs_q;
      rise_q <= rise_sel_i;
    end
  end

  // Edge flag is aligned with the pixel captured in the same stage.
  always_comb begin
    if (rise_q) line_start_o = hs_q & ~hs_p;
    else        line_start_o = ~hs_q & hs_p;
  end

  // One polarity cannot produce two line starts on consecutive clocks.
  AST_NO_BACK_TO_BACK_START: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_o |=> (!line_start_o || !$stable(rise_q)));  // R9

endmodule

// File: rtl/ldly_addr_gen.sv
module ldly_addr_gen #(
  parameter int DEPTH = 1200,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start_i,
  output logic [AW-1:0] addr_o,
  output logic          we_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] cnt_q;
  logic          full_q;

  assign addr_o = line_start_i ? '0 : cnt_q;
  assign we_o   = line_start_i | ~full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (line_start_i) begin
      if (DEPTH > 1) begin
        cnt_q  <= AW'(1);
        full_q <= 1'b0;
      end else begin
        cnt_q  <= '0;
        full_q <= 1'b1;
      end
    end else if (!full_q) begin
      if (cnt_q == LAST) full_q <= 1'b1;
      else               cnt_q  <= cnt_q + AW'(1);
    end
  end

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);  // R10

  AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !line_start_i) |=> $stable(cnt_q));  // R10

  AST_RESTART_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_i |=> (line_start_i || cnt_q == AW'(DEPTH > 1 ? 1 : 0)));  // R3

endmodule

// File: rtl/ldly_line_ram.sv
module ldly_line_ram #(
  parameter int W     = 10,
  parameter int DEPTH = 1200,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  // Read returns the old word; the write lands in the same cycle.
  always_ff @(posedge clk) begin
    rdata_o <= mem[addr_i];
    if (we_i) mem[addr_i] <= wdata_i;
  end

endmodule

// File: rtl/ldly_router.sv
module ldly_router
  import ldly_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  route_t       route_i,
  input  logic [W-1:0] thru_i,
  input  logic [W-1:0] dly_rd_i,
  output logic [W-1:0] out1_o,
  output logic [W-1:0] out2_o
);
  route_t       route_q;
  logic [W-1:0] thru_q;

  // Stage 2: match the read latency of the line store.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      thru_q  <= '0;
    end else begin
      route_q <= route_i;
      thru_q  <= thru_i;
    end
  end

  // Stage 3: registered output steering.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out1_o <= '0;
      out2_o <= '0;
    end else if (route_q.dly_to_out1) begin
      out1_o <= dly_rd_i;
      out2_o <= thru_q;
    end else begin
      out1_o <= thru_q;
      out2_o <= dly_rd_i;
    end
  end

  AST_DLY_ON_OUT1: assert property (@(posedge clk) disable iff (!rst_n)
    route_q.dly_to_out1 |=> (out1_o == $past(dly_rd_i) && out2_o == $past(thru_q)));  // R5

  AST_DLY_ON_OUT2: assert property (@(posedge clk) disable iff (!rst_n)
    !route_q.dly_to_out1 |=> (out2_o == $past(dly_rd_i) && out1_o == $past(thru_q)));  // R4

endmodule

// File: rtl/line_delay_swapper.sv
module line_delay_swapper
  import ldly_pkg::*;
#(
  parameter int PIX_W      = 10,
  parameter int LINE_DEPTH = 1200,
  localparam int AW        = (LINE_DEPTH > 1) ? $clog2(LINE_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             hsync,
  input  logic             hs_rise_sel,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             sel_a_inv,
  input  logic [PIX_W-1:0] in1_pix,
  input  logic [PIX_W-1:0] in2_pix,
  output logic [PIX_W-1:0] out1_pix,
  output logic [PIX_W-1:0] out2_pix
);
  // Stage 1: capture pixels and their routing decision together.
  logic [PIX_W-1:0] in1_q, in2_q;
  route_t           route_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      in1_q   <= '0;
      in2_q   <= '0;
      route_q <= '0;
    end else begin
      in1_q   <= in1_pix;
      in2_q   <= in2_pix;
      route_q <= decode_route(sel_a, sel_b, sel_a_inv);
    end
  end

  logic [PIX_W-1:0] wr_pix, thru_pix, rd_pix;
  assign wr_pix   = route_q.dly_from_in2 ? in2_q : in1_q;
  assign thru_pix = route_q.dly_from_in2 ? in1_q : in2_q;

  logic          line_start;
  logic [AW-1:0] addr;
  logic          we;

  ldly_sync_edge u_edge (
    .clk          (clk),
    .rst_n        (clr_n),
    .hsync_i      (hsync),
    .rise_sel_i   (hs_rise_sel),
    .line_start_o (line_start)
  );

  ldly_addr_gen #(.DEPTH(LINE_DEPTH)) u_addr (
    .clk          (clk),
    .rst_n        (clr_n),
    .line_start_i (line_start),
    .addr_o       (addr),
    .we_o         (we)
  );

  ldly_line_ram #(.W(PIX_W), .DEPTH(LINE_DEPTH)) u_ram (
    .clk     (clk),
    .addr_i  (addr),
    .we_i    (we),
    .wdata_i (wr_pix),
    .rdata_o (rd_pix)
  );

  ldly_router #(.W(PIX_W)) u_route (
    .clk      (clk),
    .rst_n    (clr_n),
    .route_i  (route_q),
    .thru_i   (thru_pix),
    .dly_rd_i (rd_pix),
    .out1_o   (out1_pix),
    .out2_o   (out2_pix)
  );

endmodule

// File: tb/sim_line_delay_swapper.sv
`timescale 1ns/1ps
module sim_line_delay_swapper;
  localparam int W     = 10;
  localparam int DEPTH = 1200;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         hsync = 1'b0, hs_rise_sel = 1'b1;
  logic         sel_a = 1'b0, sel_b = 1'b0, sel_a_inv = 1'b0;
  logic [W-1:0] in1_pix = '0, in2_pix = '0;
  logic [W-1:0] out1_pix, out2_pix;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  line_delay_swapper #(.PIX_W(W), .LINE_DEPTH(DEPTH)) u0 (
    .clk(clk), .clr_n(clr_n), .hsync(hsync), .hs_rise_sel(hs_rise_sel),
    .sel_a(sel_a), .sel_b(sel_b), .sel_a_inv(sel_a_inv),
    .in1_pix(in1_pix), .in2_pix(in2_pix),
    .out1_pix(out1_pix), .out2_pix(out2_pix)
  );

  // Expectation queue, entry 0 is the oldest (driven three cycles ago).
  logic [W-1:0] q_e1 [3];
  logic [W-1:0] q_e2 [3];
  bit           q_c1 [3];
  bit           q_c2 [3];
  string        q_t1 [3];
  string        q_t2 [3];

  function automatic logic [W-1:0] pv(int line, int pos, int port);
    return W'((line * 97 + pos * 7 + port * 301 + 5) % 1024);
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_queue();
    for (int i = 0; i < 3; i++) begin
      q_c1[i] = 1'b0; q_c2[i] = 1'b0;
      q_e1[i] = '0;   q_e2[i] = '0;
      q_t1[i] = "";   q_t2[i] = "";
    end
  endtask

  // One pixel clock: check the oldest expectation, then drive new inputs.
  task automatic cycle(logic [W-1:0] a, logic [W-1:0] b, logic hs,
                       logic [W-1:0] e1, bit c1, string t1,
                       logic [W-1:0] e2, bit c2, string t2);
    @(negedge clk);
    if (q_c1[0]) check(q_t1[0], out1_pix, q_e1[0]);
    if (q_c2[0]) check(q_t2[0], out2_pix, q_e2[0]);
    for (int i = 0; i < 2; i++) begin
      q_e1[i] = q_e1[i+1]; q_c1[i] = q_c1[i+1]; q_t1[i] = q_t1[i+1];
      q_e2[i] = q_e2[i+1]; q_c2[i] = q_c2[i+1]; q_t2[i] = q_t2[i+1];
    end
    q_e1[2] = e1; q_c1[2] = c1; q_t1[2] = t1;
    q_e2[2] = e2; q_c2[2] = c2; q_t2[2] = t2;
    in1_pix = a;
    in2_pix = b;
    hsync   = hs;
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) cycle('0, '0, hsync, '0, 0, "", '0, 0, "");
  endtask

  // One line: six blanking pixels at the idle sync level, then len pixels.
  task automatic run_line(int line, int len, bit chk_dly, int chk_max, string tag);
    bit   eff_a, src2, to1;
    logic idle;
    eff_a = sel_a ^ sel_a_inv;
    src2  = eff_a ^ sel_b;
    to1   = sel_b;
    idle  = hs_rise_sel ? 1'b0 : 1'b1;
    for (int i = 0; i < 6; i++)
      cycle(pv(line, 3000 + i, 1), pv(line, 3000 + i, 2), idle, '0, 0, "", '0, 0, "");
    for (int p = 0; p < len; p++) begin
      logic [W-1:0] thr, dly;
      bit           cd;
      thr = pv(line, p, src2 ? 1 : 2);
      dly = pv(line - 1, p, src2 ? 2 : 1);
      cd  = chk_dly && (p < chk_max);
      if (to1)
        cycle(pv(line, p, 1), pv(line, p, 2), ~idle,
              dly, cd, {tag, " R3 delayed out1"}, thr, 1'b1, "R2 undelayed out2");
      else
        cycle(pv(line, p, 1), pv(line, p, 2), ~idle,
              thr, 1'b1, "R2 undelayed out1", dly, cd, {tag, " R3 delayed out2"});
    end
  endtask

  task automatic t_reset();
    clr_n = 1'b0;
    clear_queue();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R1 out1 in clear", out1_pix, '0);
      check("R1 out2 in clear", out2_pix, '0);
      in1_pix = W'(100 + i);
      in2_pix = W'(200 + i);
      hsync   = ~hsync;
    end
    @(negedge clk);
    hsync = hs_rise_sel ? 1'b0 : 1'b1;
    clr_n = 1'b1;
  endtask

  task automatic t_route(bit a, bit b, bit inv, bit rise, int base, string tag);
    @(negedge clk);
    sel_a = a; sel_b = b; sel_a_inv = inv; hs_rise_sel = rise;
    run_line(base, 24, 1'b0, 0, tag);
    run_line(base + 1, 24, 1'b1, 24, tag);
    run_line(base + 2, 17, 1'b1, 17, tag);
    flush();
  endtask

  task automatic t_overflow();
    @(negedge clk);
    sel_a = 1'b1; sel_b = 1'b0; sel_a_inv = 1'b0; hs_rise_sel = 1'b1;
    run_line(40, DEPTH + 5, 1'b0, 0, "R10");
    run_line(41, DEPTH + 5, 1'b1, DEPTH, "R10");
    run_line(42, 30, 1'b1, 30, "R10");
    flush();
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_queue();
    t_reset();
    t_route(1'b0, 1'b0, 1'b0, 1'b1, 1,  "R4 R9");
    t_route(1'b0, 1'b1, 1'b0, 1'b0, 5,  "R5 R9");
    t_route(1'b1, 1'b0, 1'b0, 1'b1, 9,  "R6");
    t_route(1'b1, 1'b1, 1'b0, 1'b0, 13, "R7 R9");
    t_route(1'b1, 1'b0, 1'b1, 1'b1, 17, "R8");
    t_route(1'b0, 1'b1, 1'b1, 1'b0, 21, "R8");
    t_overflow();
    t_reset();
    t_route(1'b0, 1'b0, 1'b1, 1'b0, 30, "R8 R9");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule